// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides, at each instruction boundary, whether an interrupt is taken. If one is, it runs the whole entry sequence on a single memory port. Three kinds of source can compete:

- software requests from the execution side: an explicit type, a breakpoint, or a conditional overflow trap;
- an edge-latched non-maskable input;
- a level-sampled maskable input, which is gated by an interrupt-enable flag kept inside the block.

For a maskable interrupt the sequencer first runs an acknowledge bus cycle and reads the interrupt type byte from the data bus. The other sources carry their type with them. The sequencer then pushes three words onto the stack in this order: the flags, the code segment, the instruction pointer. It clears the interrupt-enable flag and signals the execution side to clear its trap flag. Next it reads the new instruction pointer and code segment from the vector table at four times the type number. It ends with a one-cycle load pulse that carries the new IP, the new CS and the decremented stack pointer.

The execution side raises `boundary` for one cycle between instructions. It presents the current flags, CS, IP, SS and SP in that cycle. These values are captured when an interrupt is accepted. The memory port performs one transfer per operation and holds it until `mem_rdy` is high at a clock edge.

Top module: `irq_vector_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `bus_op`=0 (idle), `load_vld`=0, `ie_flag`=0 and no non-maskable request is pending.
- R2: A one-cycle `ie_set` sets `ie_flag` and a one-cycle `ie_clr` clears it. When both are high in the same cycle, the flag is cleared.
- R3: A high `intr_in` is accepted at a boundary only when `ie_flag` is 1. When `ie_flag` is 0 the request causes no bus activity and `busy` stays 0.
- R4: A maskable entry starts with an acknowledge cycle (`bus_op`=3, `mem_addr`=0). The type is taken from `mem_rdata[7:0]` of that cycle. No other source produces an acknowledge cycle.
- R5: A rising edge on `nmi_in` is latched until it is serviced as type 2, without an acknowledge cycle and regardless of `ie_flag`. Holding the input high after service does not trigger it again.
- R6: Priority at a boundary is: explicit software type, then breakpoint (type 3), then overflow trap, then non-maskable, then maskable. Requests that lose are not latched, except the non-maskable one.
- R7: An overflow request is taken as type 4 only when `flags_in[11]` is 1. Otherwise it is ignored.
- R8: The entry writes three words (`bus_op`=1) in this order:
  - the flags, with bit 9 replaced by the current `ie_flag`, at SS*16 + (SP-2);
  - CS at SS*16 + (SP-4);
  - IP at SS*16 + (SP-6).

  Offsets wrap at 16 bits and physical addresses wrap at 20 bits.
- R9: When the flags write completes, `ie_flag` becomes 0 and `trap_clr` pulses for exactly one cycle. There is one pulse per entry.
- R10: After the pushes the block reads (`bus_op`=2) the word at type*4, which becomes the new IP, and then the word at type*4+2, which becomes the new CS. It then raises `load_vld` for one cycle with `new_ip`, `new_cs` and `new_sp` = SP-6.
- R11: Each bus operation keeps the same op, address and write data until `mem_rdy` is high. A boundary that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction boundary strobe |
| soft_req | input | 1 | Software interrupt with explicit type |
| soft_type | input | 8 | Type for `soft_req` |
| brk_req | input | 1 | Breakpoint request (type 3) |
| ovf_req | input | 1 | Overflow trap request (type 4 if OF set) |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| intr_in | input | 1 | Maskable request, level-sensitive |
| ie_set | input | 1 | Set interrupt-enable flag |
| ie_clr | input | 1 | Clear interrupt-enable flag |
| flags_in | input | 16 | Current flags word (bit 11 overflow) |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| bus_op | output | 2 | 0 idle, 1 write, 2 read, 3 acknowledge |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read / acknowledge data |
| mem_rdy | input | 1 | Current operation completes at this edge |
| busy | output | 1 | Entry sequence in progress |
| ie_flag | output | 1 | Interrupt-enable flag |
| trap_clr | output | 1 | One-cycle request to clear the trap flag |
| load_vld | output | 1 | New IP/CS/SP valid |
| new_ip | output | 16 | Handler instruction pointer |
| new_cs | output | 16 | Handler code segment |
| new_sp | output | 16 | Stack pointer after the pushes |

## Verification
A corrupted captured type shows up as a wrong vector address on the first read after the third push, a few cycles after acceptance. A corrupted arbitration choice or state sequence shows up as an acknowledge cycle that should not be there, or one that is missing, as the very first bus operation of an entry. A stuck or lost non-maskable latch shows at the next boundary: either the port stays quiet or an unrequested type-2 entry begins. Enable-flag errors appear as a wrong bit 9 in the first pushed word, or as a maskable request being accepted or refused at the following boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int WORD_W    = 16;
    localparam int PHYS_W    = 20;
    localparam int TYPE_W    = 8;
    localparam int SEG_SHIFT = PHYS_W - WORD_W;
    localparam int IE_BIT    = 9;
    localparam int OF_BIT    = 11;

    localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;
    localparam logic [TYPE_W-1:0] BRK_TYPE = 8'd3;
    localparam logic [TYPE_W-1:0] OVF_TYPE = 8'd4;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_WR   = 2'd1,
        BUS_RD   = 2'd2,
        BUS_ACK  = 2'd3
    } bus_op_t;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_SOFT, SRC_BRK, SRC_OVF, SRC_NMI, SRC_INTR
    } src_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK, ST_PSH_F, ST_PSH_CS, ST_PSH_IP, ST_VEC_LO, ST_VEC_HI, ST_LOAD
    } seq_st_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] ss;
        logic [WORD_W-1:0] sp;
        logic [TYPE_W-1:0] vtype;
    } ctx_t;

    function automatic logic [PHYS_W-1:0] phys(input logic [WORD_W-1:0] seg,
                                               input logic [WORD_W-1:0] off);
        return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
    endfunction

    function automatic logic [WORD_W-1:0] vec_off(input logic [TYPE_W-1:0] t,
                                                  input logic hi);
        return {{(WORD_W-TYPE_W-2){1'b0}}, t, hi, 1'b0};
    endfunction
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_pkg::*;
#(
    parameter bit EDGE_MODE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic clear,
    output logic pending
);
    logic pin_q;
    logic hit;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin;
    end

    generate
        if (EDGE_MODE) begin : g_edge
            assign hit = pin & ~pin_q;
        end else begin : g_level
            assign hit = pin;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (pend_q & ~clear) | hit;
    end

    assign pending = pend_q;

    // R5: a latched request survives until the sequencer consumes it
    assert_nmi_held_R5: assert property (@(posedge clk) disable iff (rst)
        (pending && !clear) |=> pending);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic              boundary,
    input  logic              idle,
    input  logic              soft_req,
    input  logic [TYPE_W-1:0] soft_type,
    input  logic              brk_req,
    input  logic              ovf_req,
    input  logic              of_flag,
    input  logic              nmi_pend,
    input  logic              intr,
    input  logic              ie,
    output logic              take,
    output src_t              src,
    output logic [TYPE_W-1:0] vtype
);
    always_comb begin
        src   = SRC_NONE;
        vtype = '0;
        if (boundary && idle) begin
            if (soft_req) begin
                src   = SRC_SOFT;
                vtype = soft_type;
            end else if (brk_req) begin
                src   = SRC_BRK;
                vtype = BRK_TYPE;
            end else if (ovf_req && of_flag) begin
                src   = SRC_OVF;
                vtype = OVF_TYPE;
            end else if (nmi_pend) begin
                src   = SRC_NMI;
                vtype = NMI_TYPE;
            end else if (intr && ie) begin
                src   = SRC_INTR;
            end
        end
    end

    assign take = (src != SRC_NONE);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  src_t              src,
    input  ctx_t              ctx_in,
    input  logic              ie,
    input  logic              mem_rdy,
    input  logic [WORD_W-1:0] mem_rdata,
    output bus_op_t           bus_op,
    output logic [PHYS_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              flags_done,
    output logic              load_vld,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_cs,
    output logic [WORD_W-1:0] new_sp
);
    seq_st_t           st;
    ctx_t              ctx_q;
    src_t              src_q;
    logic [WORD_W-1:0] ip_lo_q;
    logic [WORD_W-1:0] cs_hi_q;
    logic [WORD_W-1:0] flag_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctx_q   <= '0;
            src_q   <= SRC_NONE;
            ip_lo_q <= '0;
            cs_hi_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (take) begin
                    ctx_q <= ctx_in;
                    src_q <= src;
                    st    <= (src == SRC_INTR) ? ST_ACK : ST_PSH_F;
                end
                ST_ACK: if (mem_rdy) begin
                    ctx_q.vtype <= mem_rdata[TYPE_W-1:0];
                    st          <= ST_PSH_F;
                end
                ST_PSH_F:  if (mem_rdy) st <= ST_PSH_CS;
                ST_PSH_CS: if (mem_rdy) st <= ST_PSH_IP;
                ST_PSH_IP: if (mem_rdy) st <= ST_VEC_LO;
                ST_VEC_LO: if (mem_rdy) begin
                    ip_lo_q <= mem_rdata;
                    st      <= ST_VEC_HI;
                end
                ST_VEC_HI: if (mem_rdy) begin
                    cs_hi_q <= mem_rdata;
                    st      <= ST_LOAD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_word         = ctx_q.flags;
        flag_word[IE_BIT] = ie;
    end

    always_comb begin
        bus_op    = BUS_IDLE;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_ACK: bus_op = BUS_ACK;
            ST_PSH_F: begin
                bus_op    = BUS_WR;
                mem_addr  = phys(ctx_q.ss, ctx_q.sp - 16'd2);
                mem_wdata = flag_word;
            end
            ST_PSH_CS: begin
                bus_op    = BUS_WR;
                mem_addr  = phys(ctx_q.ss, ctx_q.sp - 16'd4);
                mem_wdata = ctx_q.cs;
            end
            ST_PSH_IP: begin
                bus_op    = BUS_WR;
                mem_addr  = phys(ctx_q.ss, ctx_q.sp - 16'd6);
                mem_wdata = ctx_q.ip;
            end
            ST_VEC_LO: begin
                bus_op   = BUS_RD;
                mem_addr = phys('0, vec_off(ctx_q.vtype, 1'b0));
            end
            ST_VEC_HI: begin
                bus_op   = BUS_RD;
                mem_addr = phys('0, vec_off(ctx_q.vtype, 1'b1));
            end
            default: ;
        endcase
    end

    assign busy       = (st != ST_IDLE);
    assign flags_done = (st == ST_PSH_F) && mem_rdy;
    assign load_vld   = (st == ST_LOAD);
    assign new_ip     = ip_lo_q;
    assign new_cs     = cs_hi_q;
    assign new_sp     = ctx_q.sp - 16'd6;

    // R11: a pending transfer is held unchanged until the port completes it
    assert_op_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_op != BUS_IDLE && !mem_rdy) |=>
        (bus_op == $past(bus_op) && mem_addr == $past(mem_addr) && mem_wdata == $past(mem_wdata)));

    // R4: acknowledge cycles belong only to maskable entries
    assert_ack_only_intr_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_op == BUS_ACK) |-> (src_q == SRC_INTR));

    // R10: the load pulse lasts one cycle and ends the sequence
    assert_load_ends_R10: assert property (@(posedge clk) disable iff (rst)
        load_vld |=> (!busy && !load_vld && bus_op == BUS_IDLE));
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  logic        soft_req,
    input  logic [7:0]  soft_type,
    input  logic        brk_req,
    input  logic        ovf_req,
    input  logic        nmi_in,
    input  logic        intr_in,
    input  logic        ie_set,
    input  logic        ie_clr,
    input  logic [15:0] flags_in,
    input  logic [15:0] cs_in,
    input  logic [15:0] ip_in,
    input  logic [15:0] ss_in,
    input  logic [15:0] sp_in,
    output logic [1:0]  bus_op,
    output logic [19:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_rdy,
    output logic        busy,
    output logic        ie_flag,
    output logic        trap_clr,
    output logic        load_vld,
    output logic [15:0] new_ip,
    output logic [15:0] new_cs,
    output logic [15:0] new_sp
);
    logic              ie_q;
    logic              nmi_pend;
    logic              take;
    src_t              src;
    logic [TYPE_W-1:0] vtype;
    logic              flags_done;
    bus_op_t           op;
    ctx_t              ctx_in;

    always_ff @(posedge clk) begin
        if (rst)                       ie_q <= 1'b0;
        else if (flags_done || ie_clr) ie_q <= 1'b0;
        else if (ie_set)               ie_q <= 1'b1;
    end

    irq_nmi_latch #(.EDGE_MODE(1'b1)) u_nmi (
        .clk     (clk),
        .rst     (rst),
        .pin     (nmi_in),
        .clear   (take && src == SRC_NMI),
        .pending (nmi_pend)
    );

    irq_arbiter u_arb (
        .boundary  (boundary),
        .idle      (!busy),
        .soft_req  (soft_req),
        .soft_type (soft_type),
        .brk_req   (brk_req),
        .ovf_req   (ovf_req),
        .of_flag   (flags_in[OF_BIT]),
        .nmi_pend  (nmi_pend),
        .intr      (intr_in),
        .ie        (ie_q),
        .take      (take),
        .src       (src),
        .vtype     (vtype)
    );

    assign ctx_in = '{flags: flags_in, cs: cs_in, ip: ip_in, ss: ss_in, sp: sp_in, vtype: vtype};

    irq_entry_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .src        (src),
        .ctx_in     (ctx_in),
        .ie         (ie_q),
        .mem_rdy    (mem_rdy),
        .mem_rdata  (mem_rdata),
        .bus_op     (op),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .flags_done (flags_done),
        .load_vld   (load_vld),
        .new_ip     (new_ip),
        .new_cs     (new_cs),
        .new_sp     (new_sp)
    );

    assign bus_op   = op;
    assign ie_flag  = ie_q;
    assign trap_clr = flags_done;

    // R9: once the flags word is on the stack, maskable requests are shut out
    assert_ie_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        flags_done |=> !ie_flag);

    // R3: a maskable entry never begins while the enable flag is clear
    assert_ack_needs_ie_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ie_flag && !soft_req && !brk_req && !ovf_req && !nmi_pend) |=> (op != BUS_ACK));
endmodule

// File: tb/tb_irq_vector_seq.sv
module tb_irq_vector_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        boundary, soft_req, brk_req, ovf_req, nmi_in, intr_in, ie_set, ie_clr;
    logic [7:0]  soft_type;
    logic [15:0] flags_in, cs_in, ip_in, ss_in, sp_in;
    logic [1:0]  bus_op;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_rdy;
    logic        busy, ie_flag, trap_clr, load_vld;
    logic [15:0] new_ip, new_cs, new_sp;

    always #2 clk = ~clk;

    irq_vector_seq dut (.*);

    typedef struct packed {
        logic [2:0]  kind;
        logic [19:0] addr;
        logic [31:0] data;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0, n_fail = 0;
    int    entries = 0, traps = 0;
    logic  tb_ie = 1'b0;
    logic  slow = 1'b0;
    logic  stall_tog = 1'b0;
    logic [7:0] ack_byte = 8'h00;
    logic  done = 1'b0;

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return a[15:0] * 16'd7 + 16'h1234;
    endfunction

    function automatic logic [19:0] paddr(input logic [15:0] s, input logic [15:0] o);
        return ({s, 4'h0} + {4'h0, o});
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // memory / acknowledge responder
    initial begin
        mem_rdy = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            stall_tog = ~stall_tog;
            mem_rdy   = (bus_op != 2'd0) && (!slow || stall_tog);
            if (bus_op == 2'd3)      mem_rdata = {8'h5A, ack_byte};
            else if (bus_op == 2'd2) mem_rdata = mem_word(mem_addr);
            else                     mem_rdata = '0;
        end
    end

    // monitor: pops the scoreboard as transfers complete
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst) begin
                if (bus_op != 2'd0) begin
                    item_t got;
                    got.kind = {1'b0, bus_op};
                    got.addr = mem_addr;
                    got.data = {16'h0, (bus_op == 2'd1) ? mem_wdata : mem_rdata};
                    if (!mem_rdy) begin
                        if (exp_q.size() > 0)
                            chk(got.kind == exp_q[0].kind && got.addr == exp_q[0].addr,
                                "R11 stalled op", {41'h0, got.kind, got.addr},
                                {41'h0, exp_q[0].kind, exp_q[0].addr});
                    end else if (exp_q.size() == 0) begin
                        chk(1'b0, "R11 unexpected transfer", {9'h0, got}, 64'h0);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        chk(got == e, (bus_op == 2'd3) ? "R4 ack" :
                                      (bus_op == 2'd1) ? "R8 push" : "R10 vector read",
                            {9'h0, got}, {9'h0, e});
                    end
                end
                if (load_vld) begin
                    item_t got;
                    got.kind = 3'd4;
                    got.addr = {4'h0, new_sp};
                    got.data = {new_cs, new_ip};
                    if (exp_q.size() == 0) chk(1'b0, "R10 unexpected load", {9'h0, got}, 64'h0);
                    else begin
                        item_t e;
                        e = exp_q.pop_front();
                        chk(got == e, "R10 load", {9'h0, got}, {9'h0, e});
                    end
                end
                if (trap_clr) traps++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 64'h0, 64'h1);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (busy || bus_op != 2'd0) ok = 1'b0;
        end
        chk(ok, req, {62'h0, busy, 1'b0}, 64'h0);
    endtask

    task automatic pulse_ie(input logic s, input logic c);
        @(negedge clk);
        ie_set = s; ie_clr = c;
        @(negedge clk);
        ie_set = 1'b0; ie_clr = 1'b0;
        if (c) tb_ie = 1'b0; else if (s) tb_ie = 1'b1;
    endtask

    // driver: pushes expectations for one entry, then fires the boundary
    // kind: 0 soft, 1 brk, 2 ovf, 3 nmi, 4 intr (type in t)
    task automatic entry(input int kind, input logic [7:0] t, input logic [7:0] sw_t);
        logic [15:0] fw;
        item_t it;
        fw = flags_in;
        fw[9] = tb_ie;
        if (kind == 4) begin
            ack_byte = t;
            it = '{3'd3, 20'h0, {24'h0005A, t}};
            exp_q.push_back(it);
        end
        exp_q.push_back('{3'd1, paddr(ss_in, sp_in - 16'd2), {16'h0, fw}});
        exp_q.push_back('{3'd1, paddr(ss_in, sp_in - 16'd4), {16'h0, cs_in}});
        exp_q.push_back('{3'd1, paddr(ss_in, sp_in - 16'd6), {16'h0, ip_in}});
        exp_q.push_back('{3'd2, {4'h0, t, 8'h00} >> 6, {16'h0, mem_word({10'h0, t, 2'b00})}});
        exp_q.push_back('{3'd2, {10'h0, t, 2'b10}, {16'h0, mem_word({10'h0, t, 2'b10})}});
        exp_q.push_back('{3'd4, {4'h0, sp_in - 16'd6},
                          {mem_word({10'h0, t, 2'b10}), mem_word({10'h0, t, 2'b00})}});
        if (kind == 3) begin
            nmi_in = 1'b1;
            tick(2);
        end
        @(negedge clk);
        boundary  = 1'b1;
        soft_req  = (kind == 0);
        soft_type = sw_t;
        brk_req   = (kind == 1) || (kind == 0);
        ovf_req   = (kind == 2);
        @(negedge clk);
        boundary = 1'b0; soft_req = 1'b0; brk_req = 1'b0; ovf_req = 1'b0;
        entries++;
        while (busy) @(negedge clk);
        tb_ie = 1'b0;
        #1;
        chk(ie_flag == 1'b0, "R9 ie cleared after entry", {63'h0, ie_flag}, 64'h0);
        chk(exp_q.size() == 0, "R10 sequence complete", exp_q.size(), 64'h0);
    endtask

    initial begin
        rst = 1'b1;
        boundary = 0; soft_req = 0; brk_req = 0; ovf_req = 0;
        nmi_in = 0; intr_in = 0; ie_set = 0; ie_clr = 0; soft_type = 0;
        flags_in = 16'h0003; cs_in = 16'h1200; ip_in = 16'h0456;
        ss_in = 16'h3000; sp_in = 16'h0100;
        tick(3);
        rst = 1'b0;
        #1;
        // R1
        chk(!busy && bus_op == 2'd0 && !load_vld && !ie_flag, "R1 reset state",
            {bus_op, busy, load_vld, ie_flag}, 64'h0);
        quiet(3, "R1 no pending request after reset");

        // R3: masked request ignored
        intr_in = 1'b1;
        @(negedge clk); boundary = 1'b1; @(negedge clk); boundary = 1'b0;
        quiet(5, "R3 maskable ignored with IE clear");

        // R2
        pulse_ie(1'b1, 1'b0); #1;
        chk(ie_flag == 1'b1, "R2 set", ie_flag, 1);
        pulse_ie(1'b1, 1'b1); #1;
        chk(ie_flag == 1'b0, "R2 clear wins", ie_flag, 0);
        pulse_ie(1'b1, 1'b0); #1;
        chk(ie_flag == 1'b1, "R2 set again", ie_flag, 1);

        // R3 R4 R8 R10: maskable entry
        entry(4, 8'h21, 8'h00);
        // R3: still high but IE now clear
        @(negedge clk); boundary = 1'b1; @(negedge clk); boundary = 1'b0;
        quiet(4, "R3 maskable refused after entry");
        intr_in = 1'b0;

        // R5: NMI with IE clear, no retrigger while held
        slow = 1'b1;
        cs_in = 16'hABCD; ip_in = 16'h0010; flags_in = 16'h0900;
        entry(3, 8'h02, 8'h00);
        @(negedge clk); boundary = 1'b1; @(negedge clk); boundary = 1'b0;
        quiet(4, "R5 held NMI not retriggered");
        nmi_in = 1'b0;

        // R6: NMI beats maskable, then maskable
        slow = 1'b0;
        pulse_ie(1'b1, 1'b0);
        intr_in = 1'b1;
        entry(3, 8'h02, 8'h00);
        nmi_in = 1'b0;
        pulse_ie(1'b1, 1'b0);
        entry(4, 8'h40, 8'h00);

        // R6: explicit software type beats breakpoint and maskable
        pulse_ie(1'b1, 1'b0);
        entry(0, 8'h80, 8'h80);
        intr_in = 1'b0;
        entry(1, 8'h03, 8'h00);

        // R7
        flags_in = 16'h0000;
        @(negedge clk); boundary = 1'b1; ovf_req = 1'b1;
        @(negedge clk); boundary = 1'b0; ovf_req = 1'b0;
        quiet(4, "R7 overflow ignored with OF clear");
        flags_in = 16'h0800;
        entry(2, 8'h04, 8'h00);

        // R8 wrap and R11 busy ignore under stalls
        slow = 1'b1;
        ss_in = 16'hFFFF; sp_in = 16'h0002;
        fork
            entry(1, 8'h03, 8'h00);
            begin
                tick(3);
                boundary = 1'b1; soft_req = 1'b1; soft_type = 8'h77;
                @(negedge clk);
                boundary = 1'b0; soft_req = 1'b0;
            end
        join
        quiet(4, "R11 boundary while busy ignored");

        chk(traps == entries, "R9 one trap clear per entry", traps, entries);
        done = 1'b1;
        finish_run();
    end
endmodule